// File: doc/BRIEF.md
# Configuration Memory I2C Target

This block is a bus target for a two-wire serial bus. It holds the small byte-addressed configuration store of a programmable clock source: four 6-byte frequency words and one select byte whose two low bits choose the active word. A bus controller writes the store with single-byte or burst transfers. It reads the store back with three kinds of read. A current-address read continues from the internal pointer. A random read first loads the pointer through an address-only write and then issues a repeated START. A sequential read continues for as long as the controller acknowledges.

SCL and SDA are sampled into the system clock domain through a two-flop synchronizer. START, STOP and clock edges are found from the sampled values. The block never starts a transfer. It pulls SDA low only for its own ACK bits and for the zero bits of read data. The 7-bit device address is an input pin, so the integrator sets it (69h by default in the bench). The selected word index is driven out as `word_sel` and feeds the synthesizer that uses the stored words.

Top module: `cfgmem_i2c_target`

## Requirements
- R1: After reset, SDA is released (`sda_oe`=0), `word_sel` equals the `SEL_RST` parameter (00) and every frequency byte reads 00h.
- R2: The target ACKs a frame only when the 7 address bits that follow START equal `dev_addr`. On a mismatch it gives no ACK, drives nothing and ignores every later bit until the next START or STOP, so no location changes.
- R3: In a write frame (R/W=0), the byte after the device address loads the pointer. Each following data byte is stored at the pointer and is ACKed.
- R4: During a burst write the pointer increments after each data byte, so consecutive bytes land at consecutive addresses.
- R5: A frame that carries only the register address sets the pointer and stores nothing. A following read returns the byte at that address.
- R6: A read frame with no address phase returns the byte at the pointer, which holds one more than the last address written or read.
- R7: During a read, a controller ACK (SDA low in the ninth bit) makes the target send the next byte from the incremented pointer. A controller NACK ends the transfer and SDA stays released.
- R8: The pointer is 8 bits wide and wraps from FFh to 00h.
- R9: Only 10h–27h (frequency words) and 40h (select byte) are writable. Writes elsewhere are ACKed but discarded, and reads of unimplemented addresses return 00h.
- R10: A write to 40h stores bits 1:0, which drive `word_sel`. Bits 7:2 always read back as 0.
- R11: `sda_oe` is asserted only while the sampled SCL is low. It is released after every STOP. START and STOP are never detected in the same cycle.
- R12: A change of `dev_addr` takes effect for the next frame. The old address is then no longer ACKed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_addr | input | 7 | Device address the target answers to |
| scl_i | input | 1 | Serial clock from the pad |
| sda_i | input | 1 | Serial data from the pad (wired bus level) |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| word_sel | output | 2 | Index of the active frequency word |

## Verification
The checker watches several properties on every cycle: the pointer steps by one (wrapping at FFh) on every stored byte and on every byte loaded for reading, the select output holds unless the pointer addresses 40h during a write, SDA is released after an address mismatch and after STOP, and the drive on SDA begins only while SCL is low. Only the bench scenarios show what ends up in the store and on the bus. These are the values read back after single and burst writes, the discarding of writes outside the map, the masking of the reserved select bits, the data returned by current-address, random and sequential reads, a burst that wraps through 00h into 10h, and the ACK pattern seen for a mismatched or reconfigured address.

// File: rtl/cfgmem_i2c_pkg.sv
package cfgmem_i2c_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEV_ACK,
    ST_REG,
    ST_REG_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK
  } bus_state_e;

  // Pointer step: 8-bit modular increment (FFh -> 00h).
  function automatic logic [7:0] ptr_next(input logic [7:0] p);
    return 8'(p + 8'd1);
  endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_ff;
  logic [STAGES-1:0] sda_ff;
  logic              scl_d;
  logic              sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_d  <= scl_ff[STAGES-1];
      sda_d  <= sda_ff[STAGES-1];
    end
  end

  assign scl_s     = scl_ff[STAGES-1];
  assign sda_s     = sda_ff[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/cfg_i2c_engine.sv
module cfg_i2c_engine
  import cfgmem_i2c_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [6:0] dev_addr,
  input  logic       sda_s,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_det,
  input  logic       stop_det,
  input  logic [7:0] rd_data,
  output logic       sda_oe,
  output logic       wr_en,
  output logic [7:0] wr_data,
  output logic [7:0] ptr,
  output logic       rd_load,
  output logic       addr_miss
);
  bus_state_e state;
  logic [2:0] bitcnt;
  logic       byte_full;
  logic [7:0] shreg;
  logic [7:0] tx;
  logic       rw;
  logic       m_ack;

  logic addr_hit;
  logic fall_byte;

  assign addr_hit  = (shreg[7:1] == dev_addr);
  assign fall_byte = scl_fall & byte_full;
  assign wr_en     = (state == ST_WR) & fall_byte;
  assign wr_data   = shreg;
  assign addr_miss = (state == ST_DEV) & fall_byte & ~addr_hit;
  assign rd_load   = scl_fall & (((state == ST_DEV_ACK) & rw) |
                                 ((state == ST_RD_ACK) & m_ack));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      bitcnt    <= '0;
      byte_full <= 1'b0;
      shreg     <= '0;
      tx        <= '0;
      ptr       <= '0;
      sda_oe    <= 1'b0;
      rw        <= 1'b0;
      m_ack     <= 1'b0;
    end else if (start_det) begin
      state     <= ST_DEV;
      bitcnt    <= '0;
      byte_full <= 1'b0;
      sda_oe    <= 1'b0;
    end else if (stop_det) begin
      state     <= ST_IDLE;
      byte_full <= 1'b0;
      sda_oe    <= 1'b0;
    end else begin
      if (scl_rise) begin
        case (state)
          ST_DEV, ST_REG, ST_WR: begin
            shreg  <= {shreg[6:0], sda_s};
            bitcnt <= 3'(bitcnt + 3'd1);
            if (bitcnt == 3'd7) byte_full <= 1'b1;
          end
          ST_RD: begin
            bitcnt <= 3'(bitcnt + 3'd1);
            if (bitcnt == 3'd7) byte_full <= 1'b1;
          end
          ST_RD_ACK: m_ack <= ~sda_s;
          default: ;
        endcase
      end
      if (rd_load) begin
        tx     <= rd_data;
        sda_oe <= ~rd_data[7];
        ptr    <= ptr_next(ptr);
        bitcnt <= '0;
        state  <= ST_RD;
      end else if (scl_fall) begin
        case (state)
          ST_DEV: if (byte_full) begin
            byte_full <= 1'b0;
            if (addr_hit) begin
              sda_oe <= 1'b1;
              rw     <= shreg[0];
              state  <= ST_DEV_ACK;
            end else begin
              state <= ST_IDLE;
            end
          end
          ST_DEV_ACK: begin
            sda_oe <= 1'b0;
            bitcnt <= '0;
            state  <= ST_REG;
          end
          ST_REG: if (byte_full) begin
            byte_full <= 1'b0;
            ptr       <= shreg;
            sda_oe    <= 1'b1;
            state     <= ST_REG_ACK;
          end
          ST_WR: if (byte_full) begin
            byte_full <= 1'b0;
            ptr       <= ptr_next(ptr);
            sda_oe    <= 1'b1;
            state     <= ST_WR_ACK;
          end
          ST_REG_ACK, ST_WR_ACK: begin
            sda_oe <= 1'b0;
            bitcnt <= '0;
            state  <= ST_WR;
          end
          ST_RD: if (byte_full) begin
            byte_full <= 1'b0;
            sda_oe    <= 1'b0;
            state     <= ST_RD_ACK;
          end else begin
            tx     <= {tx[6:0], 1'b0};
            sda_oe <= ~tx[6];
          end
          ST_RD_ACK: state <= ST_IDLE;
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank #(
  parameter logic [7:0] FREQ_BASE  = 8'h10,
  parameter int         FREQ_BYTES = 24,
  parameter logic [7:0] SEL_ADDR   = 8'h40,
  parameter logic [1:0] SEL_RST    = 2'b00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [7:0] rd_addr,
  output logic [7:0] rd_data,
  output logic [1:0] word_sel
);
  localparam int         SW    = $clog2(FREQ_BYTES);
  localparam logic [8:0] LIMIT = 9'(FREQ_BASE) + 9'(FREQ_BYTES);

  function automatic logic in_freq(input logic [7:0] a);
    return ({1'b0, a} >= 9'(FREQ_BASE)) && ({1'b0, a} < LIMIT);
  endfunction

  function automatic logic [SW-1:0] slot_of(input logic [7:0] a);
    return SW'(a - FREQ_BASE);
  endfunction

  logic [7:0] bytes_q [FREQ_BYTES];
  logic [1:0] sel_q;

  for (genvar g = 0; g < FREQ_BYTES; g++) begin : g_byte
    localparam logic [7:0] MY_ADDR = 8'(FREQ_BASE + g);
    logic [7:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          q <= '0;
      else if (wr_en && wr_addr == MY_ADDR) q <= wr_data;
    end
    assign bytes_q[g] = q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            sel_q <= SEL_RST;
    else if (wr_en && wr_addr == SEL_ADDR) sel_q <= wr_data[1:0];
  end

  always_comb begin
    rd_data = 8'h00;
    if (in_freq(rd_addr))          rd_data = bytes_q[slot_of(rd_addr)];
    else if (rd_addr == SEL_ADDR)  rd_data = {6'b0, sel_q};
  end

  assign word_sel = sel_q;

endmodule

// File: rtl/cfgmem_i2c_target.sv
module cfgmem_i2c_target #(
  parameter logic [7:0] FREQ_BASE   = 8'h10,
  parameter int         FREQ_BYTES  = 24,
  parameter logic [7:0] SEL_ADDR    = 8'h40,
  parameter logic [1:0] SEL_RST     = 2'b00,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [6:0] dev_addr,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  output logic [1:0] word_sel
);
  logic       scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic       wr_en, rd_load, addr_miss;
  logic [7:0] wr_data, ptr, rd_data;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  cfg_i2c_engine u_eng (
    .clk(clk), .rst_n(rst_n), .dev_addr(dev_addr), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det),
    .stop_det(stop_det), .rd_data(rd_data), .sda_oe(sda_oe), .wr_en(wr_en),
    .wr_data(wr_data), .ptr(ptr), .rd_load(rd_load), .addr_miss(addr_miss)
  );

  cfg_reg_bank #(
    .FREQ_BASE(FREQ_BASE), .FREQ_BYTES(FREQ_BYTES),
    .SEL_ADDR(SEL_ADDR), .SEL_RST(SEL_RST)
  ) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(ptr), .wr_data(wr_data),
    .rd_addr(ptr), .rd_data(rd_data), .word_sel(word_sel)
  );

endmodule

// File: rtl/cfgmem_i2c_checker.sv
module cfgmem_i2c_checker #(
  parameter logic [7:0] SEL_ADDR = 8'h40
) (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_s,
  input logic       sda_oe,
  input logic       start_det,
  input logic       stop_det,
  input logic       wr_en,
  input logic       rd_load,
  input logic       addr_miss,
  input logic [7:0] ptr,
  input logic [1:0] word_sel
);

  p_write_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ptr == 8'($past(ptr) + 8'd1));

  p_read_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_load |=> ptr == 8'($past(ptr) + 8'd1));

  p_ptr_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_en || rd_load) && ptr == 8'hFF) |=> ptr == 8'h00);

  p_sel_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && ptr == SEL_ADDR) |=> $stable(word_sel));

  p_miss_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
    addr_miss |=> !sda_oe);

  p_stop_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);

  p_drive_scl_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);

  p_cond_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_det, stop_det}));

endmodule

bind cfgmem_i2c_target cfgmem_i2c_checker #(.SEL_ADDR(SEL_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe(sda_oe),
  .start_det(start_det), .stop_det(stop_det), .wr_en(wr_en),
  .rd_load(rd_load), .addr_miss(addr_miss), .ptr(ptr), .word_sel(word_sel)
);

// File: tb/cfgmem_i2c_target_tb_top.sv
module cfgmem_i2c_target_tb_top;
  localparam int QTR = 10;
  localparam int WD  = 180000;
  localparam logic [6:0] OWN = 7'h69;
  // {register address, written byte, expected read-back}
  localparam logic [23:0] VEC [6] = '{
    24'h10A5A5, 24'h153C3C, 24'h27FFFF, 24'h1C8181, 24'h40FE02, 24'h305500
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic [6:0] dev_addr = OWN;
  logic       sda_oe;
  logic [1:0] word_sel;
  wire        sda_line = sda_m & ~sda_oe;

  int n_chk = 0, n_fail = 0, viol = 0, nacks;
  bit done = 1'b0;
  logic [7:0] wbuf [32];
  logic [7:0] rbuf [32];

  always #10 clk = ~clk;

  cfgmem_i2c_target dut_i (
    .clk(clk), .rst_n(rst_n), .dev_addr(dev_addr), .scl_i(scl_m),
    .sda_i(sda_line), .sda_oe(sda_oe), .word_sel(word_sel)
  );

  // R11: drive on SDA may not change while SCL stays high
  logic scl_prev = 1'b1, oe_prev = 1'b0;
  always @(negedge clk) begin
    if (rst_n && scl_m && scl_prev && sda_oe != oe_prev) viol++;
    scl_prev <= scl_m;
    oe_prev  <= sda_oe;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic q();
    repeat (QTR) @(negedge clk);
  endtask

  task automatic b_start();
    sda_m = 1'b1; scl_m = 1'b1; q(); sda_m = 1'b0; q(); scl_m = 1'b0; q();
  endtask

  task automatic b_rstart();
    sda_m = 1'b1; q(); scl_m = 1'b1; q(); sda_m = 1'b0; q(); scl_m = 1'b0; q();
  endtask

  task automatic b_stop();
    sda_m = 1'b0; q(); scl_m = 1'b1; q(); sda_m = 1'b1; q();
  endtask

  task automatic send(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; q(); scl_m = 1'b1; q(); q(); scl_m = 1'b0; q();
    end
    sda_m = 1'b1; q(); scl_m = 1'b1; q();
    if (sda_line) nacks++;
    q(); scl_m = 1'b0; q();
  endtask

  task automatic recv(input logic ack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; q(); scl_m = 1'b1; q(); b[i] = sda_line; q(); scl_m = 1'b0; q();
    end
    sda_m = ack; q(); scl_m = 1'b1; q(); q(); scl_m = 1'b0; q();
    sda_m = 1'b1;
  endtask

  // write frame: register address then n bytes from wbuf; nacks counts missing ACKs
  task automatic wr_frame(input logic [6:0] dev, input logic [7:0] ra, input int n);
    nacks = 0;
    b_start(); send({dev, 1'b0}); send(ra);
    for (int i = 0; i < n; i++) send(wbuf[i]);
    b_stop();
  endtask

  task automatic rd_tail(input logic [6:0] dev, input int n);
    send({dev, 1'b1});
    for (int i = 0; i < n; i++) recv((i == n - 1), rbuf[i]);
    b_stop();
  endtask

  task automatic rd_random(input logic [6:0] dev, input logic [7:0] ra, input int n);
    nacks = 0;
    b_start(); send({dev, 1'b0}); send(ra); b_rstart(); rd_tail(dev, n);
  endtask

  task automatic rd_current(input logic [6:0] dev, input int n);
    nacks = 0;
    b_start(); rd_tail(dev, n);
  endtask

  initial begin
    repeat (WD) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (8) @(negedge clk);
    chk("R1 sda released in reset", sda_oe, 0);
    chk("R1 word_sel reset", word_sel, 2'b00);
    rst_n = 1'b1;
    q();
    rd_random(OWN, 8'h10, 1);
    chk("R1 freq byte reset", rbuf[0], 8'h00);

    // table walk: single writes, random-read back (R3, R9, R10)
    for (int v = 0; v < 6; v++) begin
      wbuf[0] = VEC[v][15:8];
      wr_frame(OWN, VEC[v][23:16], 1);
      chk("R2 R9 write acked", nacks, 0);
      rd_random(OWN, VEC[v][23:16], 1);
      chk("R3 R9 R10 read back", rbuf[0], VEC[v][7:0]);
    end
    chk("R10 word_sel follows bits 1:0", word_sel, 2'b10);

    // R4 burst write, R7 sequential read
    for (int i = 0; i < 6; i++) wbuf[i] = 8'hD1 + 8'(i);
    wr_frame(OWN, 8'h16, 6);
    chk("R4 burst acked", nacks, 0);
    rd_random(OWN, 8'h16, 6);
    for (int i = 0; i < 6; i++) chk("R4 R7 sequential data", rbuf[i], 8'hD1 + 8'(i));
    chk("R7 released after NACK", sda_oe, 0);

    // R6 current-address read continues at last+1
    rd_current(OWN, 1);
    chk("R6 current after read", rbuf[0], 8'h81);
    wbuf[0] = 8'h77; wr_frame(OWN, 8'h25, 1);
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wr_frame(OWN, 8'h22, 3);
    rd_current(OWN, 1);
    chk("R6 current after burst", rbuf[0], 8'h77);

    // R5 address-only frame sets pointer without storing
    nacks = 0;
    b_start(); send({OWN, 1'b0}); send(8'h15); b_stop();
    rd_current(OWN, 1);
    chk("R5 pointer loaded", rbuf[0], 8'h3C);
    rd_random(OWN, 8'h15, 1);
    chk("R5 nothing stored", rbuf[0], 8'h3C);

    // R2 mismatched address ignored
    wbuf[0] = 8'hEE; wr_frame(7'h2A, 8'h11, 1);
    chk("R2 mismatch not acked", nacks, 3);
    rd_random(OWN, 8'h11, 1);
    chk("R2 mismatch stored nothing", rbuf[0], 8'h00);

    // R8 wrap: burst from FFh, 18th byte lands at 10h
    for (int i = 0; i < 18; i++) wbuf[i] = (i == 17) ? 8'h5A : 8'h99;
    wr_frame(OWN, 8'hFF, 18);
    chk("R9 out-of-map bytes acked", nacks, 0);
    rd_random(OWN, 8'h10, 1);
    chk("R8 wrap to 00h", rbuf[0], 8'h5A);
    rd_random(OWN, 8'h05, 1);
    chk("R9 unimplemented reads 00", rbuf[0], 8'h00);

    // R12 reconfigured address
    dev_addr = 7'h33; q();
    wbuf[0] = 8'hC3; wr_frame(7'h33, 8'h11, 1);
    chk("R12 new address acked", nacks, 0);
    wbuf[0] = 8'h11; wr_frame(OWN, 8'h11, 1);
    chk("R12 old address refused", nacks, 3);
    rd_random(7'h33, 8'h11, 1);
    chk("R12 data via new address", rbuf[0], 8'hC3);

    chk("R11 no drive change with SCL high", viol, 0);
    chk("R11 released after stop", sda_oe, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule